// File: doc/BRIEF.md
# Flag-setting integer ALU

This block is the data-processing slice of an integer datapath. Each accepted operation takes two operands, a 4-bit operation code, the current carry flag and a flag-write enable. It returns one registered result and keeps four condition flags: negative, zero, carry and overflow. The arithmetic group covers addition and subtraction. Each has a form that consumes the incoming carry, and subtraction also has reverse forms in which the operands swap roles. The logical group covers AND, OR, exclusive OR, OR with inverted second operand, and bit clear. Three byte-reordering modes convert between byte orders.

The surrounding pipeline presents an operation with `in_valid` for one cycle. The result appears one cycle later with `out_valid`. In subtraction the carry flag means "no borrow", so chained multiword subtraction works with the carry-consuming forms. For logical and byte-order operations the carry comes from an external shifter through `shift_carry`, and overflow is left alone.

Top module: `dp_alu`

## Requirements
- R1: When an accepted operation with a legal code has `set_flags` high, the next `flag_n` equals the top result bit and the next `flag_z` is 1 exactly when every result bit is 0.
- R2: Code 0 returns a+b and code 1 returns a+b+`carry_in`. With flags enabled, C is the unsigned carry out of the top bit and V is set when the exact signed sum does not fit the result width.
- R3: Code 2 returns a-b and code 3 returns a-b-(1-`carry_in`). With flags enabled, C is 1 when no borrow occurs, that is when unsigned a is at least the amount subtracted. V is set when the exact signed difference does not fit.
- R4: Code 4 returns b-a and code 5 returns b-a-(1-`carry_in`), with C and V as in R3 but with the operands swapped.
- R5: Code 6 returns a AND b, code 7 a OR b, code 8 a XOR b, code 9 a OR NOT b and code 10 a AND NOT b.
- R6: For codes 6 to 13 with flags enabled, C takes the value of `shift_carry` and V keeps its previous value.
- R7: Code 11 reverses the byte order of the whole word, so 0x3795AC5F gives 0x5FAC9537.
- R8: Code 12 swaps the two bytes inside each 16-bit half, so 0xB6D34B9D gives 0xD3B69D4B. Code 13 swaps the two low bytes and sign-extends from the new bit 15, so 0x456789AB gives 0xFFFFAB89 and 0xA0A0AA55 gives 0x000055AA.
- R9: When `set_flags` is low, or no operation is accepted, all four flags keep their values.
- R10: Codes 14 and 15 return a result of 0 and leave all four flags unchanged, even with `set_flags` high.
- R11: An operation is accepted on a rising edge with `in_valid` high. `out_valid` is high in exactly the cycle after each accepted operation. `result` holds its value while no operation is accepted.
- R12: A synchronous reset clears `result`, all four flags and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept the operation presented this cycle |
| opcode | input | 4 | Operation code (see requirements) |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| carry_in | input | 1 | Carry flag consumed by codes 1, 3 and 5 |
| shift_carry | input | 1 | Carry from the external shifter, written to C by logical and byte-order codes |
| set_flags | input | 1 | Allow the accepted operation to update the flags |
| out_valid | output | 1 | Result of an accepted operation is present |
| result | output | DATA_W | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The flags are state that outlives the operation that wrote them. A wrong flag-write decision therefore shows up at the flag ports in the cycle after the offending operation and stays there until the next flag-setting operation overwrites it. A wrong operand steering or carry-in choice inside the adder shows at `result`, and in C or V, one cycle after acceptance. Such a fault only appears for operand pairs near the sign and carry boundaries. A fault in V retention for logical codes stays hidden until an earlier arithmetic overflow has left V set. For this reason the sweep interleaves all codes over operand pairs at both sign boundaries and predicts each flag from a model it carries across operations.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDC  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBC  = 4'd3,
      OP_RSUB  = 4'd4,
      OP_RSUBC = 4'd5,
      OP_AND   = 4'd6,
      OP_OR    = 4'd7,
      OP_XOR   = 4'd8,
      OP_ORNOT = 4'd9,
      OP_CLR   = 4'd10,
      OP_BSWAP = 4'd11,
      OP_HSWAP = 4'd12,
      OP_HSEXT = 4'd13,
      OP_RSV14 = 4'd14,
      OP_RSV15 = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   function automatic logic op_is_arith(alu_op_e op);
      return (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB, OP_RSUBC});
   endfunction

   function automatic logic op_is_bitwise(alu_op_e op);
      return (op inside {OP_AND, OP_OR, OP_XOR, OP_ORNOT, OP_CLR});
   endfunction

   function automatic logic op_is_reorder(alu_op_e op);
      return (op inside {OP_BSWAP, OP_HSWAP, OP_HSEXT});
   endfunction

endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
   import dp_alu_pkg::*;
#(
   parameter int W        = 32,
   parameter int ADD_IMPL = 0
)(
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           cin,
   output logic [W-1:0]   sum,
   output logic           c_out,
   output logic           v_out
);

   logic [W-1:0] x;
   logic [W-1:0] y;
   logic         k;

   // operand steering: subtraction is x + ~y + (1 - borrow)
   always_comb begin
      x = a;
      y = b;
      k = 1'b0;
      case (op)
         OP_ADD:   begin x = a; y = b;  k = 1'b0; end
         OP_ADDC:  begin x = a; y = b;  k = cin;  end
         OP_SUB:   begin x = a; y = ~b; k = 1'b1; end
         OP_SUBC:  begin x = a; y = ~b; k = cin;  end
         OP_RSUB:  begin x = b; y = ~a; k = 1'b1; end
         OP_RSUBC: begin x = b; y = ~a; k = cin;  end
         default:  begin x = a; y = b;  k = 1'b0; end
      endcase
   end

   generate
      if (ADD_IMPL == 0) begin : g_behav
         logic [W:0] full;
         assign full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, k};
         assign sum   = full[W-1:0];
         assign c_out = full[W];
         assign v_out = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
      end else begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = k;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
         end
         assign c_out = cy[W];
         assign v_out = cy[W] ^ cy[W-1];
      end
   endgenerate

endmodule

// File: rtl/dp_alu_bitwise.sv
module dp_alu_bitwise
   import dp_alu_pkg::*;
#(
   parameter int W = 32
)(
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);

   always_comb begin
      case (op)
         OP_AND:   y = a & b;
         OP_OR:    y = a | b;
         OP_XOR:   y = a ^ b;
         OP_ORNOT: y = a | ~b;
         OP_CLR:   y = a & ~b;
         default:  y = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu_byterev.sv
module dp_alu_byterev
   import dp_alu_pkg::*;
#(
   parameter int W = 32
)(
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   output logic [W-1:0]   y
);

   localparam int NBYTES = W / 8;
   localparam int NHALF  = W / 16;

   logic [W-1:0] word_sw;
   logic [W-1:0] half_sw;
   logic [W-1:0] low_sx;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_word
         assign word_sw[8*i +: 8] = a[8*(NBYTES-1-i) +: 8];
      end
      for (genvar h = 0; h < NHALF; h++) begin : g_half
         assign half_sw[16*h +: 8]     = a[16*h + 8 +: 8];
         assign half_sw[16*h + 8 +: 8] = a[16*h +: 8];
      end
      if (W > 16) begin : g_ext
         assign low_sx = {{(W-16){a[7]}}, a[7:0], a[15:8]};
      end else begin : g_noext
         assign low_sx = {a[7:0], a[15:8]};
      end
   endgenerate

   always_comb begin
      case (op)
         OP_BSWAP: y = word_sw;
         OP_HSWAP: y = half_sw;
         OP_HSEXT: y = low_sx;
         default:  y = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADD_IMPL = 0,
   parameter bit REV_EN   = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              carry_in,
   input  logic              shift_carry,
   input  logic              set_flags,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_width
         $error("dp_alu: DATA_W must be a multiple of 16");
      end
      if (ADD_IMPL != 0 && ADD_IMPL != 1) begin : g_bad_impl
         $error("dp_alu: ADD_IMPL must be 0 or 1");
      end
   endgenerate

   alu_op_e     op_e;
   logic [MSB:0] arith_y;
   logic [MSB:0] bit_y;
   logic [MSB:0] rev_y;
   logic         arith_c;
   logic         arith_v;
   logic         sel_arith;
   logic         sel_bit;
   logic         sel_rev;
   logic         legal;
   logic [MSB:0] res_d;
   alu_flags_t   flags_q;
   alu_flags_t   flags_d;

   assign op_e = alu_op_e'(opcode);

   dp_alu_adder #(.W(DATA_W), .ADD_IMPL(ADD_IMPL)) adder_i (
      .op    (op_e),
      .a     (op_a),
      .b     (op_b),
      .cin   (carry_in),
      .sum   (arith_y),
      .c_out (arith_c),
      .v_out (arith_v)
   );

   dp_alu_bitwise #(.W(DATA_W)) bitwise_i (
      .op (op_e),
      .a  (op_a),
      .b  (op_b),
      .y  (bit_y)
   );

   generate
      if (REV_EN) begin : g_rev
         dp_alu_byterev #(.W(DATA_W)) byterev_i (
            .op (op_e),
            .a  (op_a),
            .y  (rev_y)
         );
         assign sel_rev = op_is_reorder(op_e);
      end else begin : g_norev
         assign rev_y   = '0;
         assign sel_rev = 1'b0;
      end
   endgenerate

   assign sel_arith = op_is_arith(op_e);
   assign sel_bit   = op_is_bitwise(op_e);
   assign legal     = sel_arith | sel_bit | sel_rev;

   always_comb begin
      if (sel_arith)    res_d = arith_y;
      else if (sel_bit) res_d = bit_y;
      else if (sel_rev) res_d = rev_y;
      else              res_d = '0;
   end

   always_comb begin
      flags_d = flags_q;
      if (set_flags && legal) begin
         flags_d.n = res_d[MSB];
         flags_d.z = (res_d == '0);
         if (sel_arith) begin
            flags_d.c = arith_c;
            flags_d.v = arith_v;
         end else begin
            flags_d.c = shift_carry;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         flags_q   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= res_d;
            flags_q <= flags_d;
         end
      end
   end

   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_c = flags_q.c;
   assign flag_v = flags_q.v;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit REV_EN = 1'b1
)(
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [3:0]        opcode,
   input logic              shift_carry,
   input logic              set_flags,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_v
);

   logic       known_op;
   logic       nonarith_op;
   logic [3:0] flag_vec;

   assign known_op    = (opcode <= 4'd10) || (REV_EN && opcode <= 4'd13);
   assign nonarith_op = known_op && (opcode >= 4'd6);
   assign flag_vec    = {flag_n, flag_z, flag_c, flag_v};

   assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && set_flags) |=> $stable(flag_vec));

   assert_nz_track_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && set_flags && known_op) |=>
         (flag_n == result[DATA_W-1]) && (flag_z == (result == '0)));

   assert_logic_cv_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && set_flags && nonarith_op) |=>
         $stable(flag_v) && (flag_c == $past(shift_carry)));

   assert_unused_op_R10: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !known_op) |=> (result == '0) && $stable(flag_vec));

endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W), .REV_EN(REV_EN)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .opcode      (opcode),
   .shift_carry (shift_carry),
   .set_flags   (set_flags),
   .out_valid   (out_valid),
   .result      (result),
   .flag_n      (flag_n),
   .flag_z      (flag_z),
   .flag_c      (flag_c),
   .flag_v      (flag_v)
);

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [3:0]  opcode = 4'd0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic        shift_carry = 1'b0;
   logic        set_flags = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [3:0] exp_f;   // {n,z,c,v}

   always #5 clk = ~clk;

   dp_alu dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .shift_carry(shift_carry), .set_flags(set_flags),
      .out_valid(out_valid), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic string op_tag(input int op);
      if (op <= 1)  return "R2";
      if (op <= 3)  return "R3";
      if (op <= 5)  return "R4";
      if (op <= 10) return "R5";
      if (op == 11) return "R7";
      if (op <= 13) return "R8";
      return "R10";
   endfunction

   localparam longint SMAX = 64'sd2147483647;
   localparam longint SMIN = -64'sd2147483648;

   // reference model built from the requirement text
   task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic k, output logic [31:0] r,
                        output logic c, output logic v);
      longint ux, uy, sx, sy, u, s;
      logic [31:0] x, y;
      c = 1'b0; v = 1'b0; r = '0;
      x = (op == 4 || op == 5) ? b : a;
      y = (op == 4 || op == 5) ? a : b;
      ux = longint'({32'd0, x});
      uy = longint'({32'd0, y});
      sx = longint'(signed'(x));
      sy = longint'(signed'(y));
      case (op)
         0, 1: begin
            u = ux + uy + ((op == 1) ? longint'(k) : 0);
            s = sx + sy + ((op == 1) ? longint'(k) : 0);
            r = u[31:0];
            c = (u > 64'sd4294967295);
            v = (s > SMAX) || (s < SMIN);
         end
         2, 3, 4, 5: begin
            u = ux - uy - (((op == 3) || (op == 5)) ? (1 - longint'(k)) : 0);
            s = sx - sy - (((op == 3) || (op == 5)) ? (1 - longint'(k)) : 0);
            r = u[31:0];
            c = (u >= 0);
            v = (s > SMAX) || (s < SMIN);
         end
         6:  r = a & b;
         7:  r = a | b;
         8:  r = a ^ b;
         9:  r = a | ~b;
         10: r = a & ~b;
         11: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
         12: r = {a[23:16], a[31:24], a[7:0], a[15:8]};
         13: r = {{16{a[7]}}, a[7:0], a[15:8]};
         default: r = '0;
      endcase
   endtask

   task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic k, input logic sc, input logic sf);
      logic [31:0] r;
      logic c, v;
      logic [31:0] held;
      string nz_tag, cv_tag;
      bit legal;
      legal = (op <= 13);
      model(op, a, b, k, r, c, v);
      if (sf && legal) begin
         if (op <= 5) exp_f = {r[31], (r == 32'd0), c, v};
         else         exp_f = {r[31], (r == 32'd0), sc, exp_f[0]};
      end
      nz_tag = !legal ? "R10" : (sf ? "R1" : "R9");
      cv_tag = !legal ? "R10" : (!sf ? "R9" : (op >= 6 ? "R6" : op_tag(op)));
      @(negedge clk);
      opcode = 4'(op); op_a = a; op_b = b; carry_in = k;
      shift_carry = sc; set_flags = sf; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R11", {31'd0, out_valid}, 32'd1);
      chk(op_tag(op), result, r);
      chk(nz_tag, {30'd0, flag_n, flag_z}, {30'd0, exp_f[3:2]});
      chk(cv_tag, {30'd0, flag_c, flag_v}, {30'd0, exp_f[1:0]});
      held = result;
      op_a = ~a; opcode = 4'd0; set_flags = 1'b1;
      @(negedge clk);
      chk("R11", {31'd0, out_valid}, 32'd0);
      chk("R11", result, held);
      chk("R9", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, exp_f});
   endtask

   logic [31:0] pats [12];

   initial begin
      pats[0]  = 32'h0000_0000; pats[1]  = 32'h0000_0001;
      pats[2]  = 32'h7FFF_FFFF; pats[3]  = 32'h8000_0000;
      pats[4]  = 32'hFFFF_FFFF; pats[5]  = 32'h3795_AC5F;
      pats[6]  = 32'hB6D3_4B9D; pats[7]  = 32'h4567_89AB;
      pats[8]  = 32'h2244_6688; pats[9]  = 32'h7755_3311;
      pats[10] = 32'h0000_FFFF; pats[11] = 32'h8000_0001;
      exp_f = 4'd0;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12: reset state
      chk("R12", result, 32'd0);
      chk("R12", {27'd0, out_valid, flag_n, flag_z, flag_c, flag_v}, 32'd0);

      // directed vectors with literal expectations
      run_op(0, 32'h2244_6688, 32'h7755_3311, 1'b0, 1'b0, 1'b1);
      chk("R2", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'b1001);
      run_op(11, 32'h3795_AC5F, 32'd0, 1'b0, 1'b0, 1'b0);
      chk("R7", result, 32'h5FAC_9537);
      run_op(12, 32'hB6D3_4B9D, 32'd0, 1'b0, 1'b0, 1'b0);
      chk("R8", result, 32'hD3B6_9D4B);
      run_op(13, 32'h4567_89AB, 32'd0, 1'b0, 1'b0, 1'b0);
      chk("R8", result, 32'hFFFF_AB89);
      run_op(13, 32'hA0A0_AA55, 32'd0, 1'b0, 1'b0, 1'b0);
      chk("R8", result, 32'h0000_55AA);
      run_op(2, 32'd5, 32'd5, 1'b0, 1'b0, 1'b1);
      chk("R3", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'b0110);

      // sweep over every code, operand pair and carry value
      for (int op = 0; op < 16; op++) begin
         for (int ia = 0; ia < 12; ia++) begin
            for (int ib = 0; ib < 12; ib++) begin
               for (int k = 0; k < 2; k++) begin
                  run_op(op, pats[ia], pats[ib], k[0],
                         ((ia ^ ib) & 1) != 0, ((ia + ib + op + k) % 4) != 0);
               end
            end
         end
      end

      // R12: reset after activity clears everything
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R12", result, 32'd0);
      chk("R12", {27'd0, out_valid, flag_n, flag_z, flag_c, flag_v}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule